// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces the sequence of tuning words that drives a phase-accumulator synthesizer core. While its enable input is low it passes the active profile tuning word straight through. When the enable goes high it starts from a programmed start word. It then adds a signed delta word to the current word once per step interval. The step interval is set by a rate value.

Two sweep kinds are selectable.

- **Ramped sweep.** The ramp ends at a terminating word. A mode bit chooses what happens on arrival: the controller either stays on the terminating word, or jumps back to the start word on the next clock and ramps again.
- **Open-ended sweep.** The sweep has no endpoints. The word wraps modulo 2^W and keeps stepping until the hold input is raised or the delta is set to zero.

Lowering the enable drops all sweep progress, and the output goes back to the profile word. Every change of the output word is flagged by a one-cycle strobe.

Top module: `freq_sweep_ctrl`

## Requirements
- R1: While `sweep_en` is low, `tw_out` takes the value `profile_word` had in the previous cycle. After the first clock edge with `sweep_en` low, all sweep progress is discarded.
- R2: In the first cycle with `sweep_en` high after it was low, `tw_out` loads `start_word` on that clock edge.
- R3: Steps occur every `step_rate + 1` clocks, so a `step_rate` of 0 steps on every clock. The first step comes `step_rate + 1` clocks after the start word is loaded.
- R4: With `ramp_mode` = 1 and `rtz_mode` = 0, a step that reaches or passes `end_word` loads exactly `end_word`. The word then stays there until `sweep_en` falls.
- R5: With `ramp_mode` = 1 and `rtz_mode` = 1, the cycle after `end_word` is output, `tw_out` returns to `start_word`. The step timer restarts from zero, so the next step follows `step_rate + 1` clocks later.
- R6: With `ramp_mode` = 0, there is no endpoint check. The word is `tw_out + delta_word` modulo 2^W.
- R7: While `hold` is high, both `tw_out` and the step timer are frozen. After `hold` falls, the pending step completes after the remaining clocks of its interval.
- R8: A `delta_word` of zero stops all stepping, and `tw_out` stays unchanged.
- R9: `delta_word` is two's complement. A negative delta sweeps downward, and in ramped mode the terminating word is then approached from above.
- R10: `tw_valid` is high for exactly the cycles in which `tw_out` differs from its value in the previous cycle.
- R11: During reset, `tw_out` is 0 and `tw_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sweep_en | input | 1 | Sweep enable; low selects the profile word |
| ramp_mode | input | 1 | 1 = ramp to a terminating word, 0 = open-ended |
| rtz_mode | input | 1 | In ramped mode, 1 = jump back to start at the end |
| hold | input | 1 | Freezes the word and the step timer |
| profile_word | input | W | Tuning word used while the sweep is disabled |
| start_word | input | W | First word of a sweep |
| end_word | input | W | Terminating word for ramped mode |
| delta_word | input | W | Signed increment added per step |
| step_rate | input | RW | Clocks between steps minus one |
| tw_out | output | W | Current tuning word |
| tw_valid | output | 1 | One-cycle strobe on each change of `tw_out` |

## Verification
The assertions assume the following inputs stay steady for as long as the sweep is enabled: `start_word`, `end_word`, `ramp_mode`, `rtz_mode` and `step_rate`. Only `hold` and `delta_word` are expected to move mid-sweep. The stimulus follows this rule. It reprograms the endpoints, modes and rate only while `sweep_en` is low. It asserts `hold` and clears the delta at negative edges chosen by counting the step interval, so each expected step lands on a predictable clock edge.

// File: rtl/fsweep_pkg.sv
// Package: shared types for the linear frequency sweep controller.
// Assumes nothing beyond being compiled before the modules that import it.
package fsweep_pkg;

    // Sweep sequencing states.
    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,   // disabled, word follows the profile word
        SW_RUN  = 2'd1,   // stepping
        SW_WRAP = 2'd2,   // terminating word shown, jump to start next
        SW_DONE = 2'd3    // parked on the terminating word
    } sweep_state_e;

endpackage

// File: rtl/fsweep_rate_timer.sv
// Module: fsweep_rate_timer
// Counts system clocks between sweep steps and raises a tick once per
// interval of (rate + 1) clocks. Clear forces the count to zero; when not
// running and not cleared, the count is frozen (used by hold).
// Assumes rate is steady while running; a rate lowered below the current
// count still ticks on the next running cycle.
module fsweep_rate_timer #(
    parameter int RW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [RW-1:0] rate,
    output logic          tick
);

    logic [RW-1:0] cnt_q;

    // Tick when the count has reached the programmed interval.
    always_comb tick = run && (cnt_q >= rate);

    // Advance, wrap on tick, clear, or hold the interval count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    // A frozen timer keeps its count (R7).
    p_cnt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !run) |=> $stable(cnt_q));

    // After a tick the next interval starts from zero (R3).
    p_tick_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (cnt_q == '0));

endmodule

// File: rtl/fsweep_limit.sv
// Module: fsweep_limit
// Combinational next-word calculator. Adds the signed delta to the current
// word with two guard bits, gives the modulo-2^W sum for open-ended use, and
// flags whether the sum reaches or passes the terminating word in the
// direction of the delta.
// Assumes delta is two's complement and words are unsigned.
module fsweep_limit #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] delta,
    input  logic [W-1:0] end_word,
    output logic [W-1:0] cand,
    output logic         reached
);

    localparam int EW = W + 2;

    logic signed [EW-1:0] cur_ext;
    logic signed [EW-1:0] delta_ext;
    logic signed [EW-1:0] end_ext;
    logic signed [EW-1:0] sum_ext;
    logic                 going_up;

    // Extend operands so carries and borrows stay visible in the compare.
    always_comb begin
        cur_ext   = $signed({2'b00, cur_word});
        delta_ext = $signed({{2{delta[W-1]}}, delta});
        end_ext   = $signed({2'b00, end_word});
        sum_ext   = cur_ext + delta_ext;
        going_up  = !delta[W-1];
    end

    // Wrapped sum and directional endpoint test.
    always_comb begin
        cand    = sum_ext[W-1:0];
        reached = going_up ? (sum_ext >= end_ext) : (sum_ext <= end_ext);
    end

endmodule

// File: rtl/fsweep_engine.sv
// Module: fsweep_engine
// Sequencer holding the current tuning word and the sweep state. Loads the
// profile word while disabled, the start word on enable, applies steps on
// timer ticks with clamping or wrap-back in ramped mode, and registers a
// change flag aligned with the word.
// Assumes start, end, modes and rate are steady while enabled.
module fsweep_engine
    import fsweep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sweep_en,
    input  logic         ramp_mode,
    input  logic         rtz_mode,
    input  logic         hold,
    input  logic [W-1:0] profile_word,
    input  logic [W-1:0] start_word,
    input  logic [W-1:0] end_word,
    input  logic [W-1:0] delta_word,
    input  logic         tick,
    input  logic [W-1:0] cand,
    input  logic         reached,
    output logic         timer_clear,
    output logic         timer_run,
    output logic [W-1:0] word_q,
    output logic         chg_q
);

    sweep_state_e state_q, state_d;
    logic [W-1:0] word_d;
    logic         delta_zero;

    // Timer control: count only while stepping and not held.
    always_comb begin
        delta_zero  = (delta_word == '0);
        timer_clear = !(sweep_en && (state_q == SW_RUN));
        timer_run   = sweep_en && (state_q == SW_RUN) && !hold;
    end

    // Next word and next state.
    always_comb begin
        word_d  = word_q;
        state_d = state_q;
        if (!sweep_en) begin
            word_d  = profile_word;
            state_d = SW_OFF;
        end else begin
            case (state_q)
                SW_OFF: begin
                    word_d  = start_word;
                    state_d = SW_RUN;
                end
                SW_RUN: begin
                    if (tick && !delta_zero) begin
                        if (ramp_mode && reached) begin
                            word_d  = end_word;
                            state_d = rtz_mode ? SW_WRAP : SW_DONE;
                        end else begin
                            word_d = cand;
                        end
                    end
                end
                SW_WRAP: begin
                    if (!hold) begin
                        word_d  = start_word;
                        state_d = SW_RUN;
                    end
                end
                default: begin
                    state_d = SW_DONE;
                end
            endcase
        end
    end

    // State, word and change-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SW_OFF;
            word_q  <= '0;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            chg_q   <= (word_d != word_q);
        end
    end

    // Disabled: the word tracks the profile word (R1).
    p_profile_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_en |=> (word_q == $past(profile_word)));

    // Enabling loads the start word (R2).
    p_enable_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_OFF) |=> (word_q == $past(start_word)));

    // No step without a timer tick (R3).
    p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_RUN && !tick) |=> $stable(word_q));

    // Arrival clamps to the terminating word (R4).
    p_clamp_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_RUN && tick && !delta_zero && ramp_mode && reached)
        |=> (word_q == $past(end_word)));

    // Parked sweep does not move (R4).
    p_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_DONE) |=> $stable(word_q));

    // Return-to-start one cycle after the end word (R5).
    p_wrap_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_WRAP && !hold) |=> (word_q == $past(start_word)));

    // Hold freezes the word (R7).
    p_hold_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && hold && state_q != SW_OFF) |=> $stable(word_q));

    // Zero delta never moves the word (R8).
    p_zero_delta_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_en && state_q == SW_RUN && delta_zero) |=> $stable(word_q));

endmodule

// File: rtl/freq_sweep_ctrl.sv
// Module: freq_sweep_ctrl
// Top of the linear frequency sweep controller: rate timer, next-word
// calculator and sequencer. Output word and strobe are registered.
// Assumes a single clock domain and steady sweep settings while enabled.
module freq_sweep_ctrl #(
    parameter int W  = 32,
    parameter int RW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_en,
    input  logic          ramp_mode,
    input  logic          rtz_mode,
    input  logic          hold,
    input  logic [W-1:0]  profile_word,
    input  logic [W-1:0]  start_word,
    input  logic [W-1:0]  end_word,
    input  logic [W-1:0]  delta_word,
    input  logic [RW-1:0] step_rate,
    output logic [W-1:0]  tw_out,
    output logic          tw_valid
);

    logic          tick;
    logic          timer_clear;
    logic          timer_run;
    logic [W-1:0]  cand;
    logic          reached;
    logic [W-1:0]  word_q;
    logic          chg_q;

    fsweep_rate_timer #(.RW(RW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .rate  (step_rate),
        .tick  (tick)
    );

    fsweep_limit #(.W(W)) u_limit (
        .cur_word (word_q),
        .delta    (delta_word),
        .end_word (end_word),
        .cand     (cand),
        .reached  (reached)
    );

    fsweep_engine #(.W(W)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .sweep_en     (sweep_en),
        .ramp_mode    (ramp_mode),
        .rtz_mode     (rtz_mode),
        .hold         (hold),
        .profile_word (profile_word),
        .start_word   (start_word),
        .end_word     (end_word),
        .delta_word   (delta_word),
        .tick         (tick),
        .cand         (cand),
        .reached      (reached),
        .timer_clear  (timer_clear),
        .timer_run    (timer_run),
        .word_q       (word_q),
        .chg_q        (chg_q)
    );

    // Drive the outputs from the sequencer registers.
    always_comb begin
        tw_out   = word_q;
        tw_valid = chg_q;
    end

    // Strobe marks exactly the cycles where the word changed (R10).
    p_strobe_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tw_valid == (tw_out != $past(tw_out)));

    // Reset state (R11).
    p_reset_state_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> (tw_out == '0 && !tw_valid));

endmodule

// File: tb/freq_sweep_ctrl_tb_top.sv
`timescale 1ns/1ps
module freq_sweep_ctrl_tb_top;
    localparam int W  = 32;
    localparam int RW = 20;
    localparam logic [W-1:0] PROF = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sweep_en, ramp_mode, rtz_mode, hold;
    logic [W-1:0]  profile_word, start_word, end_word, delta_word;
    logic [RW-1:0] step_rate;
    logic [W-1:0]  tw_out;
    logic          tw_valid;

    always #4 clk = ~clk;

    freq_sweep_ctrl #(.W(W), .RW(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .ramp_mode(ramp_mode),
        .rtz_mode(rtz_mode), .hold(hold), .profile_word(profile_word),
        .start_word(start_word), .end_word(end_word), .delta_word(delta_word),
        .step_rate(step_rate), .tw_out(tw_out), .tw_valid(tw_valid)
    );

    typedef struct {
        logic [W-1:0] w;
        int           gap;
        string        req;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    int   last_cyc = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor: every strobe must match the next expected word/gap.
    always @(negedge clk) begin
        if (rst_n && tw_valid) begin
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected strobe, actual word %h, expected no change", tw_out);
            end else begin
                mon_e = expq.pop_front();
                if (tw_out !== mon_e.w || (mon_e.gap != 0 && (cyc - last_cyc) != mon_e.gap)) begin
                    fails++;
                    $display("FAIL %s: actual word %h gap %0d, expected word %h gap %0d",
                             mon_e.req, tw_out, cyc - last_cyc, mon_e.w, mon_e.gap);
                end
            end
            last_cyc = cyc;
        end
    end

    task automatic push(input logic [W-1:0] w, input int gap, input string req);
        exp_t e;
        e.w = w; e.gap = gap; e.req = req;
        expq.push_back(e);
    endtask

    task automatic check_word(input string req, input logic [W-1:0] exp_w);
        checks++;
        if (tw_out !== exp_w) begin
            fails++;
            $display("FAIL %s: actual word %h, expected %h", req, tw_out, exp_w);
        end
    endtask

    task automatic check_drained(input string req);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d pending strobes, expected 0", req, expq.size());
            expq.delete();
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Disable the sweep and expect the profile word back (R1).
    task automatic go_profile();
        push(PROF, 0, "R1");
        sweep_en = 1'b0;
        wait_neg(3);
        check_word("R1", PROF);
        check_drained("R1");
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; sweep_en = 1'b0; ramp_mode = 1'b0; rtz_mode = 1'b0;
        hold = 1'b0; profile_word = PROF; start_word = '0; end_word = '0;
        delta_word = '0; step_rate = '0;
        wait_neg(3);
        // R11: reset state.
        check_word("R11", '0);
        checks++;
        if (tw_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11: actual strobe %b, expected 0", tw_valid);
        end
        push(PROF, 0, "R1");
        rst_n = 1'b1;
        wait_neg(3);
        check_word("R1", PROF);

        // Ramped, hold at end, upward, rate 2 (R2 R3 R4).
        ramp_mode = 1'b1; rtz_mode = 1'b0;
        start_word = 32'h2000; end_word = 32'h2050; delta_word = 32'h20; step_rate = 2;
        push(32'h2000, 0, "R2");
        push(32'h2020, 3, "R3");
        push(32'h2040, 3, "R3");
        push(32'h2050, 3, "R4");
        sweep_en = 1'b1;
        wait_neg(30);
        check_word("R4", 32'h2050);
        check_drained("R4");
        go_profile();

        // Ramped with return to start, rate 3 (R5).
        rtz_mode = 1'b1;
        start_word = 32'h100; end_word = 32'h130; delta_word = 32'h10; step_rate = 3;
        push(32'h100, 0, "R5");
        push(32'h110, 4, "R5");
        push(32'h120, 4, "R5");
        push(32'h130, 4, "R5");
        push(32'h100, 1, "R5");
        push(32'h110, 4, "R5");
        push(32'h120, 4, "R5");
        push(PROF, 1, "R1");
        sweep_en = 1'b1;
        wait_neg(22);
        sweep_en = 1'b0;
        wait_neg(3);
        check_word("R1", PROF);
        check_drained("R5");

        // Open-ended downward with wrap, hold, then zero delta (R6 R7 R8 R9).
        ramp_mode = 1'b0; rtz_mode = 1'b0;
        start_word = 32'h20; end_word = 32'h0; delta_word = 32'hFFFF_FFF0; step_rate = 1;
        push(32'h20, 0, "R6");
        push(32'h10, 2, "R9");
        push(32'h00, 2, "R9");
        push(32'hFFFF_FFF0, 2, "R6");
        push(32'hFFFF_FFE0, 12, "R7");
        push(32'hFFFF_FFD0, 2, "R7");
        sweep_en = 1'b1;
        wait_neg(8);
        hold = 1'b1;
        wait_neg(5);
        check_word("R7", 32'hFFFF_FFF0);
        wait_neg(5);
        check_word("R7", 32'hFFFF_FFF0);
        hold = 1'b0;
        wait_neg(3);
        delta_word = '0;
        wait_neg(12);
        check_word("R8", 32'hFFFF_FFD0);
        check_drained("R6");
        go_profile();

        // Ramped downward with overshoot clamp, rate 0 (R9 R4).
        ramp_mode = 1'b1; rtz_mode = 1'b0;
        start_word = 32'h500; end_word = 32'h4C8; delta_word = 32'hFFFF_FFE0; step_rate = 0;
        push(32'h500, 0, "R2");
        push(32'h4E0, 1, "R9");
        push(32'h4C8, 1, "R9");
        sweep_en = 1'b1;
        wait_neg(15);
        check_word("R9", 32'h4C8);
        check_drained("R9");
        go_profile();

        summary();
    end
endmodule